// File: doc/BRIEF.md
# Event Queue with Usage Watermark

This block is a sixteen-slot circular queue that sits between event sources and a consumer of transfer requests. Each event carries a 2-bit kind and a 6-bit channel number. The consumer takes events from the head of the queue through a valid/ready handshake. An event that arrives while the queue is empty and the consumer is idle and ready skips storage and goes straight to the consumer in the same cycle.

The block keeps a record of how the queue has been used, for debugging after the fact. It shows the head slot index, the number of valid entries and the highest number of valid entries seen so far. A software-set threshold sets the allowed depth. Going past it sets a sticky exceeded flag and an error bit, and the error bit drives an interrupt. A readback port returns the raw contents of any slot. Slots that have already been dequeued keep their old contents until a later push overwrites them.

Top module: `evq_tracker`

## Requirements
- R1: Queued events leave through `out_type`/`out_chan` in arrival order. A slot holds the kind in bits [7:6] and the channel in bits [5:0]. Kind codes are 0 hardware-triggered, 1 manually-triggered, 2 chain-triggered and 3 quick-channel. Quick-channel numbers run from 0 to 7.
- R2: `valid_cnt` rises by one per accepted push and falls by one per pop. A push and a pop in the same cycle leave it unchanged. `head_ptr` advances by one per pop, modulo 16.
- R3: A push writes the slot at (`head_ptr` + `valid_cnt`) mod 16. `rd_entry` returns slot `rd_idx` combinationally, and dequeued slots keep their contents until they are written again.
- R4: When `ev_valid` is high, the queue is empty, `cons_idle` is high and `out_ready` is high, the event appears on the outputs in the same cycle. It is not stored, and `valid_cnt`, `head_ptr` and `wmark` do not change.
- R5: While `valid_cnt` is 16, `ev_stall` follows `ev_valid`. The event is not written and the count stays at 16, so the source must hold the event until the stall drops.
- R6: `wmark` resets to 0 and tracks the largest `valid_cnt` reached. A pulse on `clr_wm` loads the count for the next cycle.
- R7: `exc_flag` is set at the edge where the count moves above `thr`, and also while the count stays above it. The flag then stays set until a pulse on `clr_exc`, and a set in the same cycle wins over the clear.
- R8: `err_flag` sets under the same condition as `exc_flag` but clears only on `clr_err`. `err_irq` is high whenever `err_flag` is set.
- R9: After reset, `valid_cnt`, `head_ptr`, `wmark`, `exc_flag`, `err_flag`, `err_irq` and `ev_stall` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is offered |
| ev_type | input | 2 | Kind of the offered event |
| ev_chan | input | 6 | Channel of the offered event |
| ev_stall | output | 1 | Offered event refused because the queue is full |
| cons_idle | input | 1 | Consumer has no work in flight |
| out_ready | input | 1 | Consumer accepts the presented event |
| out_valid | output | 1 | An event is presented to the consumer |
| out_type | output | 2 | Kind of the presented event |
| out_chan | output | 6 | Channel of the presented event |
| thr | input | 4 | Allowed depth, 0 to 15 |
| clr_wm | input | 1 | Reload the watermark with the current count |
| clr_exc | input | 1 | Clear the exceeded flag (write-one pulse) |
| clr_err | input | 1 | Clear the error bit (write-one pulse) |
| rd_idx | input | 4 | Slot selected for readback |
| rd_entry | output | 8 | Raw contents of the selected slot |
| head_ptr | output | 4 | Slot index of the oldest valid entry |
| valid_cnt | output | 5 | Number of valid entries |
| wmark | output | 5 | Highest count observed |
| exc_flag | output | 1 | Sticky threshold-exceeded flag |
| err_flag | output | 1 | Error bit for this queue |
| err_irq | output | 1 | Error interrupt |

## Verification
The consumer outputs, the bypass path, `ev_stall` and `rd_entry` are combinational. They are due in the cycle the stimulus is applied, so the bench samples them at the falling edge inside that cycle. The count, head, watermark and the two flags are registered and change at the first rising edge after an event is accepted. The bench therefore drives inputs just after a rising edge, holds them for one cycle, and reads status at the falling edge that follows the next rising edge. A scoreboard records every event that the ports show as accepted, and compares each consumer handshake against the oldest expected event at the same falling edge.

// File: rtl/evq_tracker.sv
module evq_tracker #(
  parameter int DEPTH = 16,
  parameter int TW    = 2,
  parameter int CW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_valid,
  input  logic [TW-1:0]              ev_type,
  input  logic [CW-1:0]              ev_chan,
  output logic                       ev_stall,
  input  logic                       cons_idle,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [TW-1:0]              out_type,
  output logic [CW-1:0]              out_chan,
  input  logic [$clog2(DEPTH)-1:0]   thr,
  input  logic                       clr_wm,
  input  logic                       clr_exc,
  input  logic                       clr_err,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [TW+CW-1:0]           rd_entry,
  output logic [$clog2(DEPTH)-1:0]   head_ptr,
  output logic [$clog2(DEPTH):0]     valid_cnt,
  output logic [$clog2(DEPTH):0]     wmark,
  output logic                       exc_flag,
  output logic                       err_flag,
  output logic                       err_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;
  localparam int EW = TW + CW;
  localparam logic [NW-1:0] FULL_N = NW'(DEPTH);

  logic [EW-1:0] slots [DEPTH];
  logic [AW-1:0] head;
  logic [NW-1:0] cnt, cnt_nxt;
  logic [NW-1:0] wm;
  logic          exc, err;

  logic empty, full, bypass, push, pop, over;
  logic [AW-1:0] wr_ptr;
  logic [EW-1:0] head_ent;

  assign empty    = (cnt == '0);
  assign full     = (cnt == FULL_N);
  assign bypass   = ev_valid && empty && cons_idle && out_ready;
  assign ev_stall = ev_valid && full;
  assign push     = ev_valid && !full && !bypass;
  assign pop      = !empty && out_ready;
  assign wr_ptr   = head + cnt[AW-1:0];
  assign head_ent = slots[head];
  assign cnt_nxt  = cnt + NW'(push) - NW'(pop);
  assign over     = (cnt_nxt > {1'b0, thr}) || (cnt > {1'b0, thr});

  assign out_valid = !empty || bypass;
  assign out_type  = empty ? ev_type : head_ent[EW-1:CW];
  assign out_chan  = empty ? ev_chan : head_ent[CW-1:0];
  assign rd_entry  = slots[rd_idx];

  assign head_ptr  = head;
  assign valid_cnt = cnt;
  assign wmark     = wm;
  assign exc_flag  = exc;
  assign err_flag  = err;
  assign err_irq   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[wr_ptr] <= {ev_type, ev_chan};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      wm   <= '0;
      exc  <= 1'b0;
      err  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (pop) head <= head + 1'b1;
      if (clr_wm)            wm <= cnt_nxt;
      else if (cnt_nxt > wm) wm <= cnt_nxt;
      if (over)         exc <= 1'b1;
      else if (clr_exc) exc <= 1'b0;
      if (over)         err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cnt <= FULL_N);

  a_r2_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_stall && !empty && out_ready) |=> $stable(valid_cnt));

  a_r4_bypass_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && valid_cnt == '0 && cons_idle && out_ready) |=> (valid_cnt == '0 && $stable(head_ptr)));

  a_r5_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_cnt == FULL_N && ev_valid) |-> ev_stall);

  a_r5_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_cnt == FULL_N && !out_ready) |=> valid_cnt == FULL_N);

  a_r6_wm_covers_count: assert property (@(posedge clk) disable iff (!rst_n)
    wmark >= valid_cnt);

  a_r7_exc_on_over: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_cnt > {1'b0, thr}) |=> exc_flag);

  a_r7_exc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flag && !clr_exc) |=> exc_flag);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_irq);
endmodule

// File: tb/evq_tracker_bench.sv
module evq_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_type = '0;
  logic [5:0] ev_chan = '0;
  logic ev_stall;
  logic cons_idle = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [1:0] out_type;
  logic [5:0] out_chan;
  logic [3:0] thr = 4'd3;
  logic clr_wm = 1'b0, clr_exc = 1'b0, clr_err = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_entry;
  logic [3:0] head_ptr;
  logic [4:0] valid_cnt, wmark;
  logic exc_flag, err_flag, err_irq;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_q[$];
  logic [7:0] wr_log[$];

  always #2.5 clk = ~clk;

  evq_tracker u_evq_tracker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type), .ev_chan(ev_chan),
    .ev_stall(ev_stall), .cons_idle(cons_idle), .out_ready(out_ready), .out_valid(out_valid),
    .out_type(out_type), .out_chan(out_chan), .thr(thr), .clr_wm(clr_wm), .clr_exc(clr_exc),
    .clr_err(clr_err), .rd_idx(rd_idx), .rd_entry(rd_entry), .head_ptr(head_ptr),
    .valid_cnt(valid_cnt), .wmark(wmark), .exc_flag(exc_flag), .err_flag(err_flag),
    .err_irq(err_irq));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: accepted events are expected, handshakes are compared
  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_valid && !ev_stall) exp_q.push_back({ev_type, ev_chan});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R1 unexpected output", {out_type, out_chan}, -1);
        else chk("R1 order", {out_type, out_chan}, exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] item(input int k);
    logic [1:0] t = 2'(k % 4);
    logic [5:0] c = (t == 2'd3) ? 6'(k % 8) : 6'((k * 5) % 64);
    return {t, c};
  endfunction

  task automatic op(input logic v, input logic [7:0] e, input logic rdy);
    @(posedge clk); #1;
    ev_valid = v; {ev_type, ev_chan} = e; out_ready = rdy;
    @(posedge clk); #1;
    ev_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic qpush(input int k, input logic rdy);
    wr_log.push_back(item(k));
    op(1'b1, item(k), rdy);
  endtask

  task automatic pulse_clr(input int which);
    @(posedge clk); #1;
    if (which == 0) clr_wm = 1'b1; else if (which == 1) clr_exc = 1'b1; else clr_err = 1'b1;
    @(posedge clk); #1;
    clr_wm = 1'b0; clr_exc = 1'b0; clr_err = 1'b0;
  endtask

  task automatic peek(input string req, input int idx, input int exp);
    rd_idx = 4'(idx); #1;
    chk(req, rd_entry, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 count", valid_cnt, 0);
    chk("R9 head", head_ptr, 0);
    chk("R9 wmark", wmark, 0);
    chk("R9 exc", exc_flag, 0);
    chk("R9 irq", err_irq, 0);
    chk("R9 stall", ev_stall, 0);

    // five queued events with the consumer busy; threshold 3
    for (int k = 0; k < 5; k++) qpush(k, 1'b0);
    @(negedge clk);
    chk("R2 count after 5", valid_cnt, 5);
    chk("R6 wmark 5", wmark, 5);
    chk("R7 exc set", exc_flag, 1);
    chk("R8 err set", err_flag, 1);
    chk("R8 irq", err_irq, 1);
    for (int s = 0; s < 5; s++) peek("R3 slot", s, item(s));

    // two pops
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    chk("R2 head after pops", head_ptr, 2);
    chk("R2 count after pops", valid_cnt, 3);
    peek("R3 history slot 0", 0, item(0));
    peek("R3 history slot 1", 1, item(1));

    // push and pop together
    qpush(5, 1'b1);
    @(negedge clk);
    chk("R2 pushpop count", valid_cnt, 3);
    chk("R2 pushpop head", head_ptr, 3);
    peek("R3 write slot", 5, item(5));

    // sticky clears
    pulse_clr(1);
    @(negedge clk);
    chk("R7 exc cleared", exc_flag, 0);
    chk("R8 err still set", err_flag, 1);
    pulse_clr(2);
    @(negedge clk);
    chk("R8 irq cleared", err_irq, 0);

    // fill to full
    for (int k = 6; k < 19; k++) qpush(k, 1'b0);
    @(negedge clk);
    chk("R5 count full", valid_cnt, 16);
    chk("R6 wmark 16", wmark, 16);
    chk("R7 exc reset", exc_flag, 1);
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_type = 2'd0; ev_chan = 6'd63;
    @(negedge clk);
    chk("R5 stall", ev_stall, 1);
    @(posedge clk); #1 ev_valid = 1'b0;
    @(negedge clk);
    chk("R5 count held", valid_cnt, 16);
    peek("R5 slot untouched", 3, item(3));

    // drain everything
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (16) @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    chk("R2 drained", valid_cnt, 0);
    chk("R2 head wrap", head_ptr, 3);
    chk("R1 scoreboard empty", exp_q.size(), 0);

    // watermark clear, then bypass
    pulse_clr(0);
    @(negedge clk);
    chk("R6 wmark cleared", wmark, 0);
    cons_idle = 1'b1;
    op(1'b1, {2'd2, 6'd42}, 1'b1);
    @(negedge clk);
    chk("R4 bypass count", valid_cnt, 0);
    chk("R4 bypass head", head_ptr, 3);
    chk("R4 bypass wmark", wmark, 0);
    chk("R4 bypass consumed", exp_q.size(), 0);
    peek("R4 no write", 3, item(3));

    // empty queue but consumer busy: event is stored
    cons_idle = 1'b0;
    qpush(19, 1'b0);
    @(negedge clk);
    chk("R4 busy stores", valid_cnt, 1);
    peek("R3 busy slot", 3, item(19));
    chk("R1 out head", {out_type, out_chan}, item(19));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule